// File: doc/BRIEF.md
# Tagged Conversion Result Buffer

This block collects the results of an auto-sequencing multichannel sampler into a sixteen-slot capture store. A built-in sequencer walks through the channels selected by an enable mask. It visits them in ascending order and wraps around, and it requests one conversion every nCLK clock cycles. The converter answers with a result strobe that carries the sample and its channel number. The buffer stores each accepted result in the next free slot, in the order the results arrive.

A sequence start empties the store and rewinds the read pointer. Capture then runs until the sixteenth slot is filled or a stop pulse arrives, whichever comes first. A live fill count can be watched while capture runs. A sequential read port presents one formatted 16-bit word per slot and advances on each read strobe. A configuration bit chooses whether each word carries the channel number and a valid flag. Slots that have not been written since the last start read as zero, and so do reads past the last slot.

Top module: `tagbuf_capture`

## Requirements
- R1: The store holds at most 16 results. `fill_cnt` never exceeds 16. When the 16th result is written, `busy` drops on the same clock edge and no further conversion is requested.
- R2: Slot i holds the i-th accepted result of the session, counting from 0 in arrival order.
- R3: `conv_req` only names a channel whose bit is set in `chan_mask`. A result whose `res_chan` bit is clear in `chan_mask` is discarded and leaves `fill_cnt` unchanged.
- R4: `fill_cnt` equals the number of results accepted so far in the session, and it is updated on the edge that writes each result.
- R5: `seq_start` sets `fill_cnt` to 0, rewinds the read pointer to slot 0 and invalidates every slot. Any slot not written since then reads as 16'h0000.
- R6: Reads at pointer position 16 return 16'h0000.
- R7: With `tag_en`=1, a written slot reads as {result[11:0], channel[2:0], 1'b1}. With `tag_en`=0, it reads as {result[11:0], 4'b0000}.
- R8: Successive conversion requests are max(nclk,1) cycles apart. Two requests for the same channel are therefore k×max(nclk,1) cycles apart, where k is the number of set bits in `chan_mask`.
- R9: After start, the first request goes to the lowest enabled channel. Each later request goes to the next higher enabled channel, wrapping to the lowest. A zero mask yields no requests while `busy` stays high.
- R10: `seq_stop` clears `busy` and freezes the stored contents and `fill_cnt`. If `seq_start` and `seq_stop` are asserted together, the start wins.
- R11: Each `rd_strobe` advances the read pointer by one. The pointer saturates at 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_start | input | 1 | Begin a capture session |
| seq_stop | input | 1 | End the capture session |
| chan_mask | input | 8 | Channel enable mask, bit n enables channel n |
| nclk | input | 8 | Cycles per conversion (0 treated as 1) |
| tag_en | input | 1 | Insert channel number and valid flag into read words |
| conv_req | output | 1 | Conversion request pulse |
| conv_chan | output | 3 | Channel for the current request |
| res_valid | input | 1 | Result strobe from the converter |
| res_chan | input | 3 | Channel of the returned result |
| res_data | input | 12 | Returned sample |
| busy | output | 1 | Capture session running |
| fill_cnt | output | 5 | Number of slots filled |
| rd_strobe | input | 1 | Advance the read pointer |
| rd_word | output | 16 | Formatted word at the read pointer |

## Verification
The main sweep starts sessions with one-bit, two-bit, scattered and full enable masks, each at several nclk values with tagging alternating. The single-bit masks separate the channel-walk logic from the request timing. The scattered and full masks expose wrap-around and skipping errors in the channel search. Varying nclk together with k separates per-request spacing from per-channel spacing. A stopped session that follows a full one shows whether stale slots leak through as valid data. Injected results on a disabled channel, compared with ones on an enabled channel, show that the mask filter alone decides what is stored.

// File: rtl/tagbuf_pkg.sv
package tagbuf_pkg;
    parameter int NUM_CH = 8;
    parameter int DEPTH  = 16;
    parameter int RES_W  = 12;
    parameter int NCLK_W = 8;
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int CNT_W  = IDX_W + 1;
    localparam int WORD_W = RES_W + CH_W + 1;

    typedef struct packed {
        logic [RES_W-1:0] data;
        logic [CH_W-1:0]  chan;
        logic             valid;
    } slot_t;

    // Nearest set bit at or after (skip=0) / strictly after (skip=1) 'from', wrapping.
    function automatic logic [CH_W-1:0] pick_chan(
        input logic [NUM_CH-1:0] mask,
        input logic [CH_W-1:0]   from,
        input logic              skip
    );
        logic [CH_W-1:0] r;
        int idx;
        r = from;
        for (int off = NUM_CH - 1; off >= 0; off--) begin
            idx = (int'(from) + off + int'(skip)) % NUM_CH;
            if (mask[idx]) r = CH_W'(idx);
        end
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] fmt_word(input slot_t s, input logic tag);
        if (!s.valid)
            return '0;
        else if (tag)
            return {s.data, s.chan, 1'b1};
        else
            return {s.data, {(CH_W + 1){1'b0}}};
    endfunction
endpackage

// File: rtl/tagbuf_sequencer.sv
module tagbuf_sequencer
    import tagbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              active,
    input  logic [NUM_CH-1:0] mask,
    input  logic [NCLK_W-1:0] nclk,
    output logic              req,
    output logic [CH_W-1:0]   chan
);
    logic [NCLK_W-1:0] tmr;
    logic [NCLK_W-1:0] last_tick;

    assign last_tick = (nclk == '0) ? '0 : nclk - 1'b1;
    assign req       = active && (|mask) && (tmr == last_tick);

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr  <= '0;
            chan <= '0;
        end else if (start) begin
            tmr  <= '0;
            chan <= pick_chan(mask, '0, 1'b0);
        end else if (active) begin
            if (req) begin
                tmr  <= '0;
                chan <= pick_chan(mask, chan, 1'b1);
            end else begin
                tmr  <= tmr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tagbuf_store.sv
module tagbuf_store
    import tagbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    input  logic [NUM_CH-1:0] mask,
    input  logic              wr_valid,
    input  logic [CH_W-1:0]   wr_chan,
    input  logic [RES_W-1:0]  wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output slot_t             rd_slot,
    output logic              active,
    output logic [CNT_W-1:0]  fill
);
    logic [RES_W-1:0] data_q [DEPTH];
    logic [CH_W-1:0]  chan_q [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic             accept;
    logic             last_slot;

    assign accept    = active && wr_valid && mask[wr_chan] && (fill < CNT_W'(DEPTH));
    assign last_slot = (fill == CNT_W'(DEPTH - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            fill   <= '0;
            vld_q  <= '0;
        end else if (start) begin
            active <= 1'b1;
            fill   <= '0;
            vld_q  <= '0;
        end else begin
            if (stop || (accept && last_slot))
                active <= 1'b0;
            if (accept) begin
                fill <= fill + 1'b1;
                vld_q[fill[IDX_W-1:0]] <= 1'b1;
            end
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!start && accept && fill[IDX_W-1:0] == IDX_W'(g)) begin
                    data_q[g] <= wr_data;
                    chan_q[g] <= wr_chan;
                end
            end
        end
    endgenerate

    assign rd_slot = '{data: data_q[rd_idx], chan: chan_q[rd_idx], valid: vld_q[rd_idx]};
endmodule

// File: rtl/tagbuf_reader.sv
module tagbuf_reader
    import tagbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              strobe,
    input  logic              tag_en,
    input  slot_t             slot,
    output logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] word
);
    logic [CNT_W-1:0] ptr;
    logic             past_end;

    assign past_end = (ptr >= CNT_W'(DEPTH));
    assign idx      = ptr[IDX_W-1:0];
    assign word     = past_end ? '0 : fmt_word(slot, tag_en);

    always_ff @(posedge clk) begin
        if (rst || start)
            ptr <= '0;
        else if (strobe && !past_end)
            ptr <= ptr + 1'b1;
    end
endmodule

// File: rtl/tagbuf_capture.sv
module tagbuf_capture
    import tagbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              seq_start,
    input  logic              seq_stop,
    input  logic [NUM_CH-1:0] chan_mask,
    input  logic [NCLK_W-1:0] nclk,
    input  logic              tag_en,
    output logic              conv_req,
    output logic [CH_W-1:0]   conv_chan,
    input  logic              res_valid,
    input  logic [CH_W-1:0]   res_chan,
    input  logic [RES_W-1:0]  res_data,
    output logic              busy,
    output logic [CNT_W-1:0]  fill_cnt,
    input  logic              rd_strobe,
    output logic [WORD_W-1:0] rd_word
);
    slot_t            rd_slot;
    logic [IDX_W-1:0] rd_idx;

    tagbuf_sequencer u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (seq_start),
        .active (busy),
        .mask   (chan_mask),
        .nclk   (nclk),
        .req    (conv_req),
        .chan   (conv_chan)
    );

    tagbuf_store u_store (
        .clk      (clk),
        .rst      (rst),
        .start    (seq_start),
        .stop     (seq_stop),
        .mask     (chan_mask),
        .wr_valid (res_valid),
        .wr_chan  (res_chan),
        .wr_data  (res_data),
        .rd_idx   (rd_idx),
        .rd_slot  (rd_slot),
        .active   (busy),
        .fill     (fill_cnt)
    );

    tagbuf_reader u_rd (
        .clk    (clk),
        .rst    (rst),
        .start  (seq_start),
        .strobe (rd_strobe),
        .tag_en (tag_en),
        .slot   (rd_slot),
        .idx    (rd_idx),
        .word   (rd_word)
    );
endmodule

// File: rtl/tagbuf_capture_chk.sv
module tagbuf_capture_chk
    import tagbuf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              seq_start,
    input logic              seq_stop,
    input logic [NUM_CH-1:0] chan_mask,
    input logic              conv_req,
    input logic [CH_W-1:0]   conv_chan,
    input logic              busy,
    input logic [CNT_W-1:0]  fill_cnt,
    input logic [WORD_W-1:0] rd_word
);
    AST_FILL_MAX: assert property (@(posedge clk) disable iff (rst)
        fill_cnt <= CNT_W'(DEPTH)); // R1

    AST_FULL_HALTS: assert property (@(posedge clk) disable iff (rst)
        (fill_cnt == CNT_W'(DEPTH)) |-> !busy && !conv_req); // R1

    AST_REQ_ENABLED: assert property (@(posedge clk) disable iff (rst)
        conv_req |-> chan_mask[conv_chan]); // R3

    AST_FILL_STEP: assert property (@(posedge clk) disable iff (rst)
        !seq_start |=> (fill_cnt == $past(fill_cnt)) || (fill_cnt == $past(fill_cnt) + 1'b1)); // R4

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        seq_start |=> (fill_cnt == '0) && (rd_word == '0) && busy); // R5

    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (rst)
        (seq_stop && !seq_start) |=> !busy && !conv_req); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !conv_req); // R9
endmodule

bind tagbuf_capture tagbuf_capture_chk u_chk (.*);

// File: tb/tagbuf_capture_tb.sv
module tagbuf_capture_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        seq_start = 1'b0, seq_stop = 1'b0, tag_en = 1'b0, rd_strobe = 1'b0;
    logic [7:0]  chan_mask = 8'h00, nclk = 8'd1;
    logic        conv_req, busy;
    logic [2:0]  conv_chan;
    logic [4:0]  fill_cnt;
    logic [15:0] rd_word;
    logic        inj = 1'b0;
    logic [2:0]  inj_ch = 3'd0;
    logic        res_valid;
    logic [2:0]  res_chan;
    logic [11:0] res_data;

    int cyc = 0, total = 0, fails = 0, conv_n = 0, k_en = 0, neff = 1;
    int last_seen [8];
    logic [2:0]  exp_ch = 3'd0;
    logic [15:0] exp_word [16];
    bit mon_on = 1'b0;

    always #2 clk = ~clk;

    assign res_valid = conv_req | inj;
    assign res_chan  = inj ? inj_ch : conv_chan;
    assign res_data  = 12'((cyc * 13 + int'(res_chan) * 256) & 32'hFFF);

    tagbuf_capture u_dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] next_en(input logic [7:0] m, input int from, input bit skip);
        for (int off = 0; off < 8; off++)
            if (m[(from + off + int'(skip)) % 8]) return 3'((from + off + int'(skip)) % 8);
        return 3'(from);
    endfunction

    task automatic tick();
        @(negedge clk);
        cyc++;
        if (mon_on) begin
            chk(fill_cnt == 5'(conv_n), "R4 live fill", fill_cnt, conv_n);
            if (conv_req) begin
                chk(conv_chan == exp_ch, "R9 channel order", conv_chan, exp_ch);
                chk(conv_n < 16, "R1 no request after full", conv_n, 15);
                if (last_seen[conv_chan] >= 0)
                    chk(cyc - last_seen[conv_chan] == k_en * neff, "R8 same-channel interval",
                        cyc - last_seen[conv_chan], k_en * neff);
                last_seen[conv_chan] = cyc;
                if (conv_n < 16) begin
                    logic [11:0] d;
                    d = 12'((cyc * 13 + int'(conv_chan) * 256) & 32'hFFF);
                    exp_word[conv_n] = tag_en ? {d, conv_chan, 1'b1} : {d, 4'b0};
                end
                conv_n++;
                exp_ch = next_en(chan_mask, int'(exp_ch), 1'b1);
            end
        end
    endtask

    task automatic begin_session(input logic [7:0] m, input logic [7:0] n, input logic t);
        chan_mask = m; nclk = n; tag_en = t;
        neff = (n == 0) ? 1 : int'(n);
        k_en = $countones(m);
        conv_n = 0;
        exp_ch = next_en(m, 0, 1'b0);
        for (int i = 0; i < 8; i++) last_seen[i] = -1;
        mon_on = 1'b1;
        seq_start = 1'b1;
        tick();
        seq_start = 1'b0;
    endtask

    task automatic read_all(input string tagname);
        for (int i = 0; i < 18; i++) begin
            logic [15:0] e;
            e = (i < conv_n && i < 16) ? exp_word[i] : 16'h0000;
            chk(rd_word == e, (i >= 16) ? "R6 read past end" : tagname, rd_word, e);
            rd_strobe = 1'b1;
            tick();
            rd_strobe = 1'b0;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [7:0] masks [5];
        logic [7:0] ncs [3];
        int run;
        masks = '{8'h01, 8'h81, 8'hA5, 8'hFF, 8'h10};
        ncs   = '{8'd0, 8'd1, 8'd3};
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk(fill_cnt == 0 && !busy && !conv_req && rd_word == 0, "R5 reset state",
            {busy, conv_req, fill_cnt, rd_word}, 0);

        run = 0;
        foreach (masks[mi]) foreach (ncs[ni]) begin
            begin_session(masks[mi], ncs[ni], 1'(run % 2));
            for (int w = 0; w < 2000 && busy; w++) tick();
            repeat (3 * 8) tick();
            chk(!busy && fill_cnt == 16, "R1 auto stop at 16", {busy, fill_cnt}, 16);
            chk(conv_n == 16, "R1 request count", conv_n, 16);
            read_all(tag_en ? "R7 tagged word R2" : "R7 plain word R2");
            run++;
        end

        // Stop mid-session after a full one: stale slots must read zero
        begin_session(8'h03, 8'd4, 1'b1);
        repeat (22) tick();
        seq_stop = 1'b1; tick(); seq_stop = 1'b0;
        chk(!busy, "R10 stop clears busy", busy, 0);
        repeat (20) tick();
        chk(fill_cnt == 5 && conv_n == 5, "R10 frozen after stop", fill_cnt, 5);
        read_all("R5 stale slots zero");

        // Start beats stop
        chan_mask = 8'h04; nclk = 8'd2;
        mon_on = 1'b0;
        seq_start = 1'b1; seq_stop = 1'b1; tick();
        seq_start = 1'b0; seq_stop = 1'b0;
        chk(busy && fill_cnt == 0, "R10 start wins", {busy, fill_cnt}, 6'h20);
        seq_stop = 1'b1; tick(); seq_stop = 1'b0;

        // Empty mask
        begin_session(8'h00, 8'd1, 1'b0);
        repeat (60) tick();
        chk(conv_n == 0 && fill_cnt == 0 && busy, "R9 empty mask no requests", conv_n, 0);
        seq_stop = 1'b1; tick(); seq_stop = 1'b0;

        // Disabled-channel result filter
        begin_session(8'h01, 8'd200, 1'b1);
        mon_on = 1'b0;
        repeat (3) tick();
        inj = 1'b1; inj_ch = 3'd3; tick(); inj = 1'b0;
        chk(fill_cnt == 0, "R3 disabled channel ignored", fill_cnt, 0);
        chk(rd_word == 0, "R3 slot 0 untouched", rd_word, 0);
        inj = 1'b1; inj_ch = 3'd0; tick(); inj = 1'b0;
        chk(fill_cnt == 1, "R3 enabled channel accepted", fill_cnt, 1);
        chk(rd_word[0] == 1'b1 && rd_word[3:1] == 3'd0, "R7 tag on injected", rd_word[3:0], 1);
        rd_strobe = 1'b1; tick(); rd_strobe = 1'b0;
        chk(rd_word == 0, "R11 pointer advanced to empty slot", rd_word, 0);
        seq_stop = 1'b1; tick(); seq_stop = 1'b0;

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule